// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides the output of a fast oscillator down to the comparison rate of a phase-locked loop. A dual-modulus prescaler counts oscillator cycles in groups of P or P+1. A main counter counts N prescaler cycles per frame, and a swallow counter keeps the prescaler at P+1 for the first A of those cycles. Each frame therefore lasts P·N+A input cycles and ends with a one-cycle comparison pulse. The prescaler is modelled here as a plain cycle counter so the whole path can be simulated on the oscillator-rate clock.

Settings arrive as an N value, an A value and a prescaler-range select bit, captured on a load strobe. Illegal settings are refused and flagged. Legal settings wait in a pending slot until the running frame ends, so no frame is ever cut short or mixed. A parameter picks the frequency band, which fixes the pair of P values the select bit chooses between. With the enable low the divider is parked at the start of a frame and emits no pulses.

Top module: `pulse_swallow_div`

## Requirements
- R1: Between consecutive rising edges of `fp_o`, the divider counts exactly P·N+A enabled clock cycles for the settings in force during that frame.
- R2: With `HIGH_BAND`=0, P is 16 when the applied select bit is 1 and 32 when it is 0.
- R3: With `HIGH_BAND`=1, P is 32 when the applied select bit is 1 and 64 when it is 0.
- R4: `fp_o` is high for one clock cycle per frame.
- R5: A load accepted in the middle of a frame leaves that frame's length unchanged. The new settings govern every frame from the next one onwards.
- R6: A load sampled on the same edge that closes a frame misses that boundary. The frame that starts on that edge uses the old settings, and the new ones take effect at the boundary after it.
- R7: A load with N below 3 sets `cfg_err_o` to 1 on the next cycle and changes neither the current nor the next frame length.
- R8: A load with A not less than N is refused in the same way as in R7.
- R9: An accepted load (N at least 3 and A less than N) sets `cfg_err_o` to 0 on the next cycle.
- R10: While `en_i` is low, `fp_o` stays low and the divider holds at the start of a frame. Settings loaded at least one cycle before `en_i` rises apply to the first frame, which ends P·N+A cycles after the first enabled edge.
- R11: After reset, `fp_o` and `cfg_err_o` are 0, and the divider runs with N=`DEF_N`, A=`DEF_A` and select `DEF_SEL` (default 8, 2, 1).
- R12: In each frame, `mc_o` (1 = divide by P+1) is high for A·(P+1) cycles and low for the remainder. The swallow count always stays below the main count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | 1 = run, 0 = power saving (parked, no pulses) |
| n_i | input | NW | Main counter value N |
| a_i | input | AW | Swallow counter value A |
| sel_i | input | 1 | Prescaler range select |
| load_i | input | 1 | Captures n_i, a_i, sel_i |
| fp_o | output | 1 | One-cycle comparison pulse at the end of each frame |
| mc_o | output | 1 | Modulus control, 1 = prescaler divides by P+1 |
| cfg_err_o | output | 1 | Result of the last load, 1 = refused |

## Verification
A load can arrive on the very edge on which the main counter expires, so capture of new settings and the reload at the frame boundary fall in the same cycle. The bench times a load to the last cycle of a known-length frame by counting edges from the previous pulse. It then expects one more full frame at the old length, followed by one at the new length. A second overlap comes from re-enabling: settings loaded while parked must be applied as the frame restarts. The bench judges this by the length of the first frame after the enable rises.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned MOD_W = 7;

  // Base modulus P for band/select
  function automatic logic [MOD_W-1:0] base_mod(input logic high_band, input logic sel);
    case ({high_band, sel})
      2'b00:   return 7'd32;
      2'b01:   return 7'd16;
      2'b10:   return 7'd64;
      default: return 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/psd_cfg.sv
module psd_cfg #(
  parameter int unsigned NW      = 11,
  parameter int unsigned AW      = 7,
  parameter int unsigned DEF_N   = 8,
  parameter int unsigned DEF_A   = 2,
  parameter bit          DEF_SEL = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic          sel_i,
  input  logic          apply_i,
  output logic [NW-1:0] n_o,
  output logic [AW-1:0] a_o,
  output logic          sel_o,
  output logic          err_o
);
  logic [NW-1:0] act_n, pend_n;
  logic [AW-1:0] act_a, pend_a;
  logic          act_sel, pend_sel, pend_vld, err_q;
  logic          ok;

  assign ok = (n_i >= NW'(3)) && ({{(NW-AW){1'b0}}, a_i} < n_i);

  // Settings for the next frame
  assign n_o   = pend_vld ? pend_n   : act_n;
  assign a_o   = pend_vld ? pend_a   : act_a;
  assign sel_o = pend_vld ? pend_sel : act_sel;
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_n    <= NW'(DEF_N);
      act_a    <= AW'(DEF_A);
      act_sel  <= DEF_SEL;
      pend_n   <= NW'(DEF_N);
      pend_a   <= AW'(DEF_A);
      pend_sel <= DEF_SEL;
      pend_vld <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (load_i) begin
        err_q <= !ok;
        if (ok) begin
          pend_n   <= n_i;
          pend_a   <= a_i;
          pend_sel <= sel_i;
        end
      end
      if (apply_i) begin
        act_n   <= n_o;
        act_a   <= a_o;
        act_sel <= sel_o;
      end
      // a load on the apply edge stays pending for the next boundary
      if (load_i && ok)  pend_vld <= 1'b1;
      else if (apply_i)  pend_vld <= 1'b0;
    end
  end

  assert_keep_on_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !ok) |=> (err_q && pend_n == $past(pend_n) && pend_a == $past(pend_a)));

  assert_legal_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_n >= NW'(3)) && ({{(NW-AW){1'b0}}, act_a} < act_n));

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ok) |=> !err_q);
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned RST_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [MOD_W-1:0] len_i,
  output logic             tick_o
);
  logic [MOD_W-1:0] cnt;

  assign tick_o = en_i && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= MOD_W'(RST_LEN - 1);
    else if (!en_i || tick_o)   cnt <= len_i - 1'b1;
    else                        cnt <= cnt - 1'b1;
  end

  assert_len_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (len_i >= MOD_W'(16) && len_i <= MOD_W'(65)));

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= MOD_W'(64));
endmodule

// File: rtl/psd_frame.sv
module psd_frame
  import psd_pkg::*;
#(
  parameter int unsigned NW    = 11,
  parameter int unsigned AW    = 7,
  parameter int unsigned DEF_N = 8,
  parameter int unsigned DEF_A = 2,
  parameter int unsigned DEF_P = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [NW-1:0]    n_i,
  input  logic [AW-1:0]    a_i,
  input  logic [MOD_W-1:0] p_i,
  output logic             apply_o,
  output logic [MOD_W-1:0] len_o,
  output logic             mc_o,
  output logic             fp_o
);
  logic [NW-1:0]    n_cnt;
  logic [AW-1:0]    s_cnt, s_dec;
  logic [MOD_W-1:0] p_q;
  logic             last, fp_q;

  assign last    = tick_i && (n_cnt == NW'(1));
  assign apply_o = !en_i || last;
  assign s_dec   = (s_cnt != '0) ? s_cnt - 1'b1 : '0;
  assign mc_o    = (s_cnt != '0);
  assign fp_o    = fp_q;

  // Length of the prescaler cycle that follows this edge
  assign len_o = apply_o ? p_i + {{(MOD_W-1){1'b0}}, (a_i != '0)}
                         : p_q + {{(MOD_W-1){1'b0}}, (s_dec != '0)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_cnt <= NW'(DEF_N);
      s_cnt <= AW'(DEF_A);
      p_q   <= MOD_W'(DEF_P);
      fp_q  <= 1'b0;
    end else begin
      fp_q <= last;
      if (apply_o) begin
        n_cnt <= n_i;
        s_cnt <= a_i;
        p_q   <= p_i;
      end else if (tick_i) begin
        n_cnt <= n_cnt - 1'b1;
        s_cnt <= s_dec;
      end
    end
  end

  assert_no_fp_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fp_q);

  assert_fp_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_q |=> !fp_q);

  assert_swallow_first_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{(NW-AW){1'b0}}, s_cnt} < n_cnt);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter bit          HIGH_BAND = 1'b0,
  parameter int unsigned NW        = 11,
  parameter int unsigned AW        = 7,
  parameter int unsigned DEF_N     = 8,
  parameter int unsigned DEF_A     = 2,
  parameter bit          DEF_SEL   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  logic          sel_i,
  input  logic          load_i,
  output logic          fp_o,
  output logic          mc_o,
  output logic          cfg_err_o
);
  localparam int unsigned DEF_P   = int'(base_mod(HIGH_BAND, DEF_SEL));
  localparam int unsigned DEF_LEN = DEF_P + ((DEF_A != 0) ? 1 : 0);

  logic [NW-1:0]    nx_n;
  logic [AW-1:0]    nx_a;
  logic             nx_sel, apply, tick;
  logic [MOD_W-1:0] nx_p, len;

  assign nx_p = base_mod(HIGH_BAND, nx_sel);

  psd_cfg #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL)) i_cfg (
    .clk_i, .rst_ni, .load_i, .n_i, .a_i, .sel_i,
    .apply_i(apply), .n_o(nx_n), .a_o(nx_a), .sel_o(nx_sel), .err_o(cfg_err_o)
  );

  psd_prescaler #(.RST_LEN(DEF_LEN)) i_presc (
    .clk_i, .rst_ni, .en_i, .len_i(len), .tick_o(tick)
  );

  psd_frame #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_P(DEF_P)) i_frame (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .n_i(nx_n), .a_i(nx_a), .p_i(nx_p),
    .apply_o(apply), .len_o(len), .mc_o, .fp_o
  );
endmodule

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
module test_pulse_swallow_div;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_lo, en_hi, load, sel;
  logic [10:0] n;
  logic [6:0]  a;
  logic fp_lo, mc_lo, err_lo, fp_hi, mc_hi, err_hi;
  logic en_lo_at = 1'b1, en_hi_at = 1'b0;
  int total = 0, bad = 0, off_viol = 0;
  int cur_n = 8, cur_a = 2;
  bit cur_sel = 1'b1;

  always #2.5 clk = ~clk;

  pulse_swallow_div #(.HIGH_BAND(1'b0)) i_pulse_swallow_div (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_lo), .n_i(n), .a_i(a), .sel_i(sel),
    .load_i(load), .fp_o(fp_lo), .mc_o(mc_lo), .cfg_err_o(err_lo));

  pulse_swallow_div #(.HIGH_BAND(1'b1)) i_pulse_swallow_div_hb (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_hi), .n_i(n), .a_i(a), .sel_i(sel),
    .load_i(load), .fp_o(fp_hi), .mc_o(mc_hi), .cfg_err_o(err_hi));

  // R10 monitor: no pulse after an edge taken with the enable low
  always @(posedge clk) begin en_lo_at <= en_lo; en_hi_at <= en_hi; end
  always @(negedge clk)
    if (rst_n && ((!en_lo_at && fp_lo) || (!en_hi_at && fp_hi))) off_viol++;

  function automatic int pmod(bit hb, bit s);
    return hb ? (s ? 32 : 64) : (s ? 16 : 32);
  endfunction
  function automatic int exp_len(bit hb, bit s, int nn, int aa);
    return pmod(hb, s) * nn + aa;
  endfunction
  function automatic int exp_mc(bit hb, bit s, int aa);
    return aa * (pmod(hb, s) + 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Counts edges up to the next pulse; optional load on a chosen cycle
  task automatic measure(bit hb, int load_at, output int len, output int mcc);
    int c;
    bit done;
    bit fpv;
    c = 0; mcc = 0; done = 0;
    while (!done) begin
      load = (c == load_at);
      if (hb ? mc_hi : mc_lo) mcc++;
      @(posedge clk); @(negedge clk);
      c++;
      fpv = hb ? fp_hi : fp_lo;
      if (c == 1) chk("R4", "pulse width", int'(fpv), 0);
      if (fpv || c > 150000) done = 1;
    end
    load = 1'b0;
    len = c;
  endtask

  task automatic load_cfg(int nn, int aa, bit ss);
    n = 11'(nn); a = 7'(aa); sel = ss; load = 1'b1;
    @(posedge clk); @(negedge clk);
    load = 1'b0;
  endtask

  // Legal load right after a boundary, then old remainder and new frame
  task automatic run_cfg(bit hb, int nn, int aa, bit ss);
    int l, m, old;
    old = exp_len(hb, cur_sel, cur_n, cur_a);
    load_cfg(nn, aa, ss);
    chk("R9", "err after legal load", int'(err_lo), 0);
    cur_n = nn; cur_a = aa; cur_sel = ss;
    measure(hb, -1, l, m);
    chk("R5", "old frame remainder", l, old - 1);
    measure(hb, -1, l, m);
    chk(hb ? "R3" : "R2", "period P*N+A (R1)", l, exp_len(hb, ss, nn, aa));
    chk("R12", "mc cycles", m, exp_mc(hb, ss, aa));
  endtask

  task automatic run_bad(int nn, int aa, string req);
    int l, m, old;
    old = exp_len(1'b0, cur_sel, cur_n, cur_a);
    load_cfg(nn, aa, 1'b0);
    chk(req, "err flag", int'(err_lo), 1);
    measure(1'b0, -1, l, m);
    chk(req, "remainder kept", l, old - 1);
    measure(1'b0, -1, l, m);
    chk(req, "period kept", l, old);
  endtask

  task automatic rand_cfg(bit hb);
    int nn, aa;
    bit ss;
    nn = 3 + $urandom_range(77);
    aa = $urandom_range(nn - 1);
    ss = 1'($urandom_range(1));
    run_cfg(hb, nn, aa, ss);
  endtask

  initial begin
    #(5.0 * 199000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int l, m, old, nw;
    void'($urandom(32'd7315));
    en_lo = 1'b1; en_hi = 1'b0; load = 1'b0; n = '0; a = '0; sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11", "fp after reset", int'(fp_lo), 0);
    chk("R11", "err after reset", int'(err_lo), 0);
    chk("R11", "hb fp after reset", int'(fp_hi), 0);
    measure(1'b0, -1, l, m);
    chk("R11", "default first period", l, 130);
    measure(1'b0, -1, l, m);
    chk("R1", "default period", l, 130);
    chk("R12", "default mc cycles", m, 34);

    run_cfg(1'b0, 3, 0, 1'b1);
    run_cfg(1'b0, 3, 2, 1'b0);
    run_cfg(1'b0, 200, 127, 1'b1);
    run_bad(2, 0, "R7");
    run_bad(5, 5, "R8");
    run_cfg(1'b0, 6, 5, 1'b0);

    // R6: load lands on the closing edge of a frame
    old = exp_len(1'b0, cur_sel, cur_n, cur_a);
    n = 11'd4; a = 7'd1; sel = 1'b0;
    measure(1'b0, old - 1, l, m);
    chk("R6", "frame with boundary load", l, old);
    measure(1'b0, -1, l, m);
    chk("R6", "next frame still old", l, old);
    cur_n = 4; cur_a = 1; cur_sel = 1'b0;
    measure(1'b0, -1, l, m);
    chk("R6", "new settings applied", l, exp_len(1'b0, 1'b0, 4, 1));

    repeat (4) rand_cfg(1'b0);

    // Park low band, run high band from its parked state
    en_lo = 1'b0; en_hi = 1'b1;
    measure(1'b1, -1, l, m);
    chk("R10", "hb first frame after enable", l, exp_len(1'b1, cur_sel, cur_n, cur_a));
    measure(1'b1, -1, l, m);
    chk("R3", "hb period", l, exp_len(1'b1, cur_sel, cur_n, cur_a));
    run_cfg(1'b1, 3, 0, 1'b0);
    run_cfg(1'b1, 3, 1, 1'b1);
    repeat (4) rand_cfg(1'b1);

    // Load while parked, then restart low band
    en_hi = 1'b0;
    load_cfg(10, 9, 1'b1);
    cur_n = 10; cur_a = 9; cur_sel = 1'b1;
    @(posedge clk); @(negedge clk);
    en_lo = 1'b1;
    nw = exp_len(1'b0, 1'b1, 10, 9);
    measure(1'b0, -1, l, m);
    chk("R10", "first frame uses parked load", l, nw);
    measure(1'b0, -1, l, m);
    chk("R12", "mc cycles after restart", m, exp_mc(1'b0, 1'b1, 9));
    chk("R10", "pulses while parked", off_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule